// File: doc/BRIEF.md
# Staged Peripheral Clock-Gate Controller

This block produces the clock-enable signals for four security peripherals: a crypto engine, a random number generator, a public-key accelerator and a DMA engine. Software writes three enable words through a small write port, one each for the run, sleep and deep-sleep power modes. The run-mode word also carries one force-on bit per peripheral. A forced peripheral keeps its clock running in every power mode.

Written values sit in staging registers. They reach the gate enables only when the load strobe is pulsed, and all three words move across together on that strobe. A 2-bit power-mode input picks which active word drives the registered enable outputs. The block also raises a system-bus clock request while the crypto engine or the DMA engine is forced on. The gating cells themselves and the sequencing of the power modes sit outside this block.

Top module: `secure_clk_gate_stage`

## Requirements
- R1: After reset all staged words read 0, `gate_en_o` is 4'b0000 and `bus_clk_req_o` is 0.
- R2: Within a mode word, bit 0 enables the crypto clock (`gate_en_o[0]`), bit 1 the random generator clock (`gate_en_o[1]`), bit 2 the public-key clock (`gate_en_o[2]`) and bit 8 the DMA clock (`gate_en_o[3]`). A 1 turns the clock on.
- R3: `wr_addr_i` selects the word that is written: 0 is run, 1 is sleep and 2 is deep sleep. A write to address 3 is ignored, and address 3 reads as 0. `rd_data_o` returns the staged word at `rd_addr_i`, combinationally.
- R4: Bits 16, 17, 18 and 24 of the run word force on the crypto, random generator, public-key and DMA clocks respectively. A forced clock is on in every power mode, whatever that peripheral's enable bits are.
- R5: A write has no effect on the outputs until `load_i` is pulsed. One load transfers all three staged words at once.
- R6: When a write and `load_i` fall in the same cycle, the transfer includes the newly written data.
- R7: `bus_clk_req_o` is 1 exactly when the active crypto force bit or the active DMA force bit is set, in every power mode.
- R8: Only bits 0, 1, 2, 8, 16, 17, 18 and 24 of the run word can be stored, and only bits 0, 1, 2 and 8 of the sleep and deep-sleep words. All other bits read 0, and the force positions of the sleep and deep-sleep words have no effect on the outputs.
- R9: `pmode_i` selects the active word: 0 is run, 1 is sleep, and 2 or 3 is deep sleep. The outputs are registered. They change on the clock edge after a mode change, and on the edge after the edge that captures the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for one staged word |
| wr_addr_i | input | 2 | Word select for the write (0 run, 1 sleep, 2 deep sleep) |
| wr_data_i | input | 32 | Write data |
| load_i | input | 1 | Transfers the staged words to the active words |
| rd_addr_i | input | 2 | Word select for readback |
| rd_data_o | output | 32 | Staged word at `rd_addr_i` |
| pmode_i | input | 2 | Power mode (0 run, 1 sleep, 2 or 3 deep sleep) |
| gate_en_o | output | 4 | Clock enables: crypto, random generator, public key, DMA |
| bus_clk_req_o | output | 1 | System-bus clock request |

## Verification
The checker assumes that `load_i` and `wr_en_i` are synchronous single-cycle strobes. It also assumes that `load_i` stays low during reset, so the hold property sees a defined past value in the first cycle after reset. The bench drives every input on the falling clock edge and releases reset with all strobes low, which keeps the stimulus within these assumptions. The bench gives each strobe one full cycle and samples the outputs at least one full cycle after the capturing edge.

// File: rtl/secure_clk_gate_pkg.sv
package secure_clk_gate_pkg;

  localparam int DATA_W  = 32;
  localparam int NPERIPH = 4;
  localparam int NMODES  = 3;
  localparam int ADDR_W  = $clog2(NMODES + 1);
  localparam int PMODE_W = 2;

  // peripherals whose force bit holds the system-bus clock request
  localparam logic [NPERIPH-1:0] BUS_HOLD = 4'b1001;

  typedef enum logic [PMODE_W-1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_DEEP  = 2'd2,
    PM_DEEP2 = 2'd3
  } pmode_e;

  function automatic int en_pos(input int p);
    case (p)
      0: return 0;
      1: return 1;
      2: return 2;
      default: return 8;
    endcase
  endfunction

  function automatic int frc_pos(input int p);
    return en_pos(p) + 16;
  endfunction

  function automatic logic [DATA_W-1:0] en_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int p = 0; p < NPERIPH; p++) m[en_pos(p)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] frc_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int p = 0; p < NPERIPH; p++) m[frc_pos(p)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] RUN_MASK = en_mask() | frc_mask();
  localparam logic [DATA_W-1:0] LOW_MASK = en_mask();

endpackage

// File: rtl/secure_clk_stage_regs.sv
module secure_clk_stage_regs
  import secure_clk_gate_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int NP = NPERIPH,
  parameter int NM = NMODES,
  parameter int AW = ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [DW-1:0]          rd_data_o,
  output logic [NM-1:0][NP-1:0]  en_d_o,
  output logic [NP-1:0]          frc_d_o
);

  logic [NM-1:0][NP-1:0] en_q;
  logic [NP-1:0]         frc_q;
  logic [NP-1:0]         wr_en_bits, wr_frc_bits;
  logic [NM-1:0][DW-1:0] word;

  // reserved bits are simply never stored
  logic unused_rsvd;
  assign unused_rsvd = ^(wr_data_i & ~RUN_MASK);

  for (genvar p = 0; p < NP; p++) begin : g_extract
    assign wr_en_bits[p]  = wr_data_i[en_pos(p)];
    assign wr_frc_bits[p] = wr_data_i[frc_pos(p)];
  end

  for (genvar m = 0; m < NM; m++) begin : g_mode
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == AW'(m));
    assign en_d_o[m] = hit ? wr_en_bits : en_q[m];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[m] <= '0;
      else         en_q[m] <= en_d_o[m];
    end

    always_comb begin
      word[m] = '0;
      for (int p = 0; p < NP; p++) begin
        word[m][en_pos(p)] = en_q[m][p];
        if (m == 0) word[m][frc_pos(p)] = frc_q[p];
      end
    end
  end

  assign frc_d_o = (wr_en_i && wr_addr_i == '0) ? wr_frc_bits : frc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frc_q <= '0;
    else         frc_q <= frc_d_o;
  end

  always_comb begin
    rd_data_o = '0;
    for (int m = 0; m < NM; m++)
      if (rd_addr_i == AW'(m)) rd_data_o = word[m];
  end

endmodule

// File: rtl/secure_clk_active_regs.sv
module secure_clk_active_regs
  import secure_clk_gate_pkg::*;
#(
  parameter int NP = NPERIPH,
  parameter int NM = NMODES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [NM-1:0][NP-1:0] en_d_i,
  input  logic [NP-1:0]         frc_d_i,
  output logic [NM-1:0][NP-1:0] act_en_o,
  output logic [NP-1:0]         act_frc_o
);

  // next-state staged values: a write in the load cycle is included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_o  <= '0;
      act_frc_o <= '0;
    end else if (load_i) begin
      act_en_o  <= en_d_i;
      act_frc_o <= frc_d_i;
    end
  end

endmodule

// File: rtl/secure_clk_gate_sel.sv
module secure_clk_gate_sel
  import secure_clk_gate_pkg::*;
#(
  parameter int NP = NPERIPH,
  parameter int NM = NMODES,
  parameter int PW = PMODE_W,
  parameter logic [NP-1:0] HOLD = BUS_HOLD
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PW-1:0]         pmode_i,
  input  logic [NM-1:0][NP-1:0] act_en_i,
  input  logic [NP-1:0]         act_frc_i,
  output logic [NP-1:0]         gate_en_o,
  output logic                  bus_clk_req_o
);

  logic [NP-1:0] sel, en_d;

  // encodings above the last mode fall to the deepest mode
  always_comb begin
    sel = act_en_i[NM-1];
    for (int m = 0; m < NM - 1; m++)
      if (pmode_i == PW'(m)) sel = act_en_i[m];
  end

  for (genvar p = 0; p < NP; p++) begin : g_periph
    assign en_d[p] = sel[p] | act_frc_i[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_en_o     <= '0;
      bus_clk_req_o <= 1'b0;
    end else begin
      gate_en_o     <= en_d;
      bus_clk_req_o <= |(act_frc_i & HOLD);
    end
  end

endmodule

// File: rtl/secure_clk_gate_stage.sv
module secure_clk_gate_stage
  import secure_clk_gate_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [PMODE_W-1:0] pmode_i,
  output logic [NPERIPH-1:0] gate_en_o,
  output logic               bus_clk_req_o
);

  logic [NMODES-1:0][NPERIPH-1:0] en_d, act_en;
  logic [NPERIPH-1:0]             frc_d, act_frc;

  secure_clk_stage_regs u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .en_d_o    (en_d),
    .frc_d_o   (frc_d)
  );

  secure_clk_active_regs u_active (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .en_d_i    (en_d),
    .frc_d_i   (frc_d),
    .act_en_o  (act_en),
    .act_frc_o (act_frc)
  );

  secure_clk_gate_sel u_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pmode_i       (pmode_i),
    .act_en_i      (act_en),
    .act_frc_i     (act_frc),
    .gate_en_o     (gate_en_o),
    .bus_clk_req_o (bus_clk_req_o)
  );

endmodule

// File: rtl/secure_clk_gate_checker.sv
module secure_clk_gate_checker
  import secure_clk_gate_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           wr_en_i,
  input logic [ADDR_W-1:0]              wr_addr_i,
  input logic [DATA_W-1:0]              wr_data_i,
  input logic                           load_i,
  input logic [ADDR_W-1:0]              rd_addr_i,
  input logic [DATA_W-1:0]              rd_data_o,
  input logic [NPERIPH-1:0]             gate_en_o,
  input logic                           bus_clk_req_o,
  input logic [NMODES-1:0][NPERIPH-1:0] act_en,
  input logic [NPERIPH-1:0]             act_frc
);

  logic [DATA_W-1:0] rd_mask;
  always_comb begin
    if (rd_addr_i == '0)                       rd_mask = RUN_MASK;
    else if (int'(rd_addr_i) < NMODES)         rd_mask = LOW_MASK;
    else                                       rd_mask = '0;
  end

  assert_reset_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (gate_en_o == '0 && !bus_clk_req_o));

  assert_hold_no_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(act_en) && $stable(act_frc)));

  assert_rsvd_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~rd_mask) == '0);

  assert_bus_req_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(act_frc & BUS_HOLD) |=> bus_clk_req_o);

  assert_bus_req_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(act_frc & BUS_HOLD)) |=> !bus_clk_req_o);

  for (genvar p = 0; p < NPERIPH; p++) begin : g_chk
    assert_force_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_frc[p] |=> gate_en_o[p]);

    assert_merge_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(load_i && wr_en_i && wr_addr_i == '0) |->
        (act_en[0][p] == $past(wr_data_i[en_pos(p)]) &&
         act_frc[p]   == $past(wr_data_i[frc_pos(p)])));
  end

endmodule

bind secure_clk_gate_stage secure_clk_gate_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .load_i        (load_i),
  .rd_addr_i     (rd_addr_i),
  .rd_data_o     (rd_data_o),
  .gate_en_o     (gate_en_o),
  .bus_clk_req_o (bus_clk_req_o),
  .act_en        (act_en),
  .act_frc       (act_frc)
);

// File: tb/tb_secure_clk_gate_stage.sv
`timescale 1ns/1ps
module tb_secure_clk_gate_stage;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, load;
  logic [1:0]  wr_addr, rd_addr, pmode;
  logic [31:0] wr_data, rd_data;
  logic [3:0]  gate_en;
  logic        bus_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  secure_clk_gate_stage dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .load_i(load), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .pmode_i(pmode), .gate_en_o(gate_en),
    .bus_clk_req_o(bus_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic ld);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; load = ld;
    @(negedge clk);
    wr_en = 1'b0; load = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); pmode = m;
    settle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic clear_all();
    wr(2'd0, 32'h0, 1'b0); wr(2'd1, 32'h0, 1'b0); wr(2'd2, 32'h0, 1'b1);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 gate after reset", {28'h0, gate_en}, 32'h0);
    check("R1 bus after reset", {31'h0, bus_req}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 staged word after reset", d, 32'h0);
    end
  endtask

  task automatic t_no_effect_before_load();
    logic [31:0] d;
    set_mode(2'd0);
    wr(2'd0, 32'h0000_0105, 1'b0);
    repeat (4) @(negedge clk);
    check("R5 run write without load", {28'h0, gate_en}, 32'h0);
    rd(2'd0, d);
    check("R3 readback staged run", d, 32'h0000_0105);
    do_load(); settle();
    check("R2 run enables after load", {28'h0, gate_en}, 32'hD);
    // two words staged, one load moves both
    wr(2'd1, 32'h0000_0002, 1'b0);
    wr(2'd2, 32'h0000_0100, 1'b0);
    set_mode(2'd1);
    check("R5 sleep staged only", {28'h0, gate_en}, 32'h0);
    do_load(); settle();
    check("R5 sleep after load", {28'h0, gate_en}, 32'h2);
    set_mode(2'd2);
    check("R9 deep sleep word", {28'h0, gate_en}, 32'h8);
    set_mode(2'd3);
    check("R9 mode 3 uses deep sleep", {28'h0, gate_en}, 32'h8);
    set_mode(2'd0);
    check("R9 back to run", {28'h0, gate_en}, 32'hD);
  endtask

  task automatic t_latency();
    clear_all();
    wr(2'd0, 32'h0000_0001, 1'b0);
    wr(2'd1, 32'h0000_0002, 1'b1);
    settle();
    check("R9 run before mode change", {28'h0, gate_en}, 32'h1);
    @(negedge clk); pmode = 2'd1;
    #1;
    check("R9 mode change not yet visible", {28'h0, gate_en}, 32'h1);
    @(negedge clk);
    check("R9 mode change after one edge", {28'h0, gate_en}, 32'h2);
    wr(2'd1, 32'h0000_0004, 1'b0);
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    check("R9 load edge not yet visible", {28'h0, gate_en}, 32'h2);
    @(negedge clk);
    check("R9 load visible one edge later", {28'h0, gate_en}, 32'h4);
  endtask

  task automatic t_force();
    clear_all();
    wr(2'd0, 32'h0107_0000, 1'b1); settle();
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1:0]);
      check("R4 all forced in mode", {28'h0, gate_en}, 32'hF);
    end
    wr(2'd1, 32'h0000_0001, 1'b0);
    wr(2'd0, 32'h0002_0000, 1'b1);
    set_mode(2'd1);
    check("R4 rng forced plus sleep enable", {28'h0, gate_en}, 32'h3);
    set_mode(2'd2);
    check("R4 rng forced in deep sleep", {28'h0, gate_en}, 32'h2);
    set_mode(2'd0);
    check("R4 rng forced in run", {28'h0, gate_en}, 32'h2);
  endtask

  task automatic t_bus();
    set_mode(2'd0);
    wr(2'd0, 32'h0001_0000, 1'b1); settle();
    check("R7 crypto force requests bus", {31'h0, bus_req}, 32'h1);
    wr(2'd0, 32'h0100_0000, 1'b1); settle();
    check("R7 dma force requests bus", {31'h0, bus_req}, 32'h1);
    wr(2'd0, 32'h0004_0000, 1'b1); settle();
    check("R7 pk force no bus request", {31'h0, bus_req}, 32'h0);
    wr(2'd0, 32'h0000_0107, 1'b1); settle();
    check("R7 enables alone no bus request", {31'h0, bus_req}, 32'h0);
    wr(2'd0, 32'h0001_0000, 1'b1);
    set_mode(2'd1);
    check("R7 crypto force bus in sleep", {31'h0, bus_req}, 32'h1);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(2'd0, 32'hFFFF_FFFF, 1'b0);
    wr(2'd1, 32'hFFFF_FFFF, 1'b0);
    wr(2'd2, 32'hFFFF_FFFF, 1'b0);
    rd(2'd0, d); check("R8 run reserved masked", d, 32'h0107_0107);
    rd(2'd1, d); check("R8 sleep reserved masked", d, 32'h0000_0107);
    rd(2'd2, d); check("R8 deep reserved masked", d, 32'h0000_0107);
    wr(2'd0, 32'h0, 1'b0);
    wr(2'd1, 32'h0107_0000, 1'b0);
    wr(2'd2, 32'h0107_0000, 1'b1);
    set_mode(2'd1);
    check("R8 sleep force positions ignored", {28'h0, gate_en}, 32'h0);
    check("R8 sleep force positions no bus", {31'h0, bus_req}, 32'h0);
    set_mode(2'd2);
    check("R8 deep force positions ignored", {28'h0, gate_en}, 32'h0);
  endtask

  task automatic t_addr3();
    logic [31:0] d;
    set_mode(2'd0);
    wr(2'd0, 32'h0000_0002, 1'b1); settle();
    wr(2'd3, 32'hFFFF_FFFF, 1'b1); settle();
    rd(2'd3, d); check("R3 address 3 reads zero", d, 32'h0);
    rd(2'd0, d); check("R3 run untouched by address 3", d, 32'h0000_0002);
    rd(2'd1, d); check("R3 sleep untouched by address 3", d, 32'h0);
    check("R3 gates untouched by address 3", {28'h0, gate_en}, 32'h2);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    clear_all();
    set_mode(2'd0);
    wr(2'd0, 32'h0100_0004, 1'b1); settle();
    check("R6 same-cycle write loaded", {28'h0, gate_en}, 32'hC);
    check("R6 same-cycle force loaded", {31'h0, bus_req}, 32'h1);
    rd(2'd0, d); check("R6 staged after same-cycle", d, 32'h0100_0004);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; load = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0; pmode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_effect_before_load();
    t_latency();
    t_force();
    t_bus();
    t_reserved();
    t_addr3();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule